// File: doc/BRIEF.md
# Stop-State Output Safe Controller

This block sits between the output data of a controlling logic core and the drive pins of up to four output groups. While the core runs, each group passes its normal data straight to the pins. When the run/stop flag reports the stopped state, every group switches to a safe value. That value depends on two things: the group's bit in a small control register, which says whether the stop reset is issued, and the board type strapped for that group. The board type is discrete, differential or analog.

A configuration agent programs the control register through a dedicated write strobe. A second strobe belongs to the ordinary runtime access path. It shares the write data bus but cannot change the register. While the core is stopped, a register write reaches the pins on the cycle after the write edge, with no restart needed. A group that holds its output uses the data sampled on the last clock edge at which the run flag was high. It keeps that value for the whole stop period.

Top module: `stop_safe_out`

## Requirements
- R1: After reset the control register reads 0, so every group starts with the stop reset issued.
- R2: A write with `cfg_we_i` high stores `wr_data_i[3:0]` into register bits 3..0, one bit per group (bit g belongs to group g). The result shows on `cfg_rdata_o` after the write edge, and bits 15..4 always read 0.
- R3: A write with only `rt_we_i` high leaves the register unchanged.
- R4: While `run_i` is 1, every group drives `grp_data_i` with its enable high, whatever the register bits are.
- R5: While stopped with the group's bit at 0 (reset issued), a discrete group (type 00, and also type 11) drives all zeros with its enable high.
- R6: While stopped with the group's bit at 0, a differential group (type 01) releases its pins: the enable is 0 and the data is 0.
- R7: While stopped with the group's bit at 0, an analog group (type 10) drives a zero code with its enable high.
- R8: While stopped with the group's bit at 1, discrete and analog groups drive the data sampled on the last clock edge at which `run_i` was 1.
- R9: While stopped with the group's bit at 1, a differential group follows `diff_mode_i`. Mode 01 drives all zeros, mode 10 drives all ones, and modes 00 and 11 drive the held value. The enable stays high in every mode.
- R10: While stopped, a configuration write changes the group outputs from the cycle after the write edge.
- R11: The held value does not change while stopped, even when `grp_data_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| rt_we_i | input | 1 | Runtime access write strobe (no effect on the register) |
| wr_data_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Control register readback |
| run_i | input | 1 | 1 = running, 0 = stopped |
| diff_mode_i | input | 2 | Fallback for differential groups: 00 hold, 01 low, 10 high, 11 hold |
| board_type_i | input | 8 | Board type, 2 bits per group (group g at [2g+1:2g]) |
| grp_data_i | input | NUM_GRP*GRP_W | Normal output data, group g at [g*GRP_W +: GRP_W] |
| drv_o | output | NUM_GRP*GRP_W | Drive data per group |
| drv_oe_o | output | 4 | Drive enable per group, 0 = high impedance |

## Verification
The bench builds the block with four groups of 4 bits each, so the whole data path is 16 bits wide. This is narrow enough to sweep every register value together with every diff mode and every board-type rotation across the groups. Every combination of reset bit, board type and mode, including the reserved type code, meets each of the three stopped behaviours. In each scenario the bench runs, stops, changes the input data, rewrites the register while stopped and tries a runtime write. This exercises hold capture, immediate effect and write rejection in one pass.

// File: rtl/sso_pkg.sv
package sso_pkg;
  typedef enum logic [1:0] {
    BT_DISC = 2'b00,
    BT_DIFF = 2'b01,
    BT_ANLG = 2'b10,
    BT_RSVD = 2'b11
  } board_t;

  typedef enum logic [1:0] {
    DM_HOLD  = 2'b00,
    DM_LOW   = 2'b01,
    DM_HIGH  = 2'b10,
    DM_HOLD2 = 2'b11
  } dmode_t;
endpackage

// File: rtl/sso_ctrl_reg.sv
module sso_ctrl_reg #(
  parameter int REG_W   = 16,
  parameter int NUM_GRP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             rt_we_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [REG_W-1:0] GRP_MASK = REG_W'((1 << NUM_GRP) - 1);

  logic [REG_W-1:0] ctrl_q;

  // only the configuration strobe loads; the runtime strobe is rejected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (cfg_we_i) ctrl_q <= wr_data_i & GRP_MASK;
  end

  assign rdata_o = ctrl_q;

  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> rdata_o[NUM_GRP-1:0] == $past(wr_data_i[NUM_GRP-1:0])); // R2
  AST_RT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_we_i && !cfg_we_i) |=> $stable(rdata_o)); // R3
endmodule

// File: rtl/sso_hold_bank.sv
module sso_hold_bank #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] hold_o
);
  logic [DW-1:0] hold_q;

  // tracks data while running; freezes on the first stopped edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (run_i) hold_q <= data_i;
  end

  assign hold_o = hold_q;

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(hold_o)); // R11
  AST_HOLD_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> hold_o == $past(data_i)); // R8
endmodule

// File: rtl/sso_grp_mux.sv
module sso_grp_mux
  import sso_pkg::*;
#(
  parameter int GRP_W = 8
) (
  input  logic             run_i,
  input  logic             rst_off_i,
  input  board_t           btype_i,
  input  dmode_t           dmode_i,
  input  logic [GRP_W-1:0] data_i,
  input  logic [GRP_W-1:0] hold_i,
  output logic [GRP_W-1:0] drv_o,
  output logic             oe_o
);
  always_comb begin
    drv_o = '0;
    oe_o  = 1'b1;
    if (run_i) begin
      drv_o = data_i;
    end else if (!rst_off_i) begin
      // reset issued: off, zero code, or released
      if (btype_i == BT_DIFF) oe_o = 1'b0;
    end else if (btype_i == BT_DIFF) begin
      unique case (dmode_i)
        DM_LOW:  drv_o = '0;
        DM_HIGH: drv_o = '1;
        default: drv_o = hold_i;
      endcase
    end else begin
      drv_o = hold_i;
    end
  end
endmodule

// File: rtl/stop_safe_out.sv
module stop_safe_out
  import sso_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int NUM_GRP = 4,
  parameter int GRP_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic                     rt_we_i,
  input  logic [REG_W-1:0]         wr_data_i,
  output logic [REG_W-1:0]         cfg_rdata_o,
  input  logic                     run_i,
  input  logic [1:0]               diff_mode_i,
  input  logic [2*NUM_GRP-1:0]     board_type_i,
  input  logic [NUM_GRP*GRP_W-1:0] grp_data_i,
  output logic [NUM_GRP*GRP_W-1:0] drv_o,
  output logic [NUM_GRP-1:0]       drv_oe_o
);
  localparam int DW = NUM_GRP * GRP_W;

  logic [REG_W-1:0] ctrl;
  logic [DW-1:0]    hold;

  sso_ctrl_reg #(.REG_W(REG_W), .NUM_GRP(NUM_GRP)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_we_i (cfg_we_i),
    .rt_we_i  (rt_we_i),
    .wr_data_i(wr_data_i),
    .rdata_o  (ctrl)
  );

  sso_hold_bank #(.DW(DW)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_i),
    .data_i(grp_data_i),
    .hold_o(hold)
  );

  assign cfg_rdata_o = ctrl;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    board_t btype;
    assign btype = board_t'(board_type_i[2*g +: 2]);

    sso_grp_mux #(.GRP_W(GRP_W)) u_mux (
      .run_i    (run_i),
      .rst_off_i(ctrl[g]),
      .btype_i  (btype),
      .dmode_i  (dmode_t'(diff_mode_i)),
      .data_i   (grp_data_i[g*GRP_W +: GRP_W]),
      .hold_i   (hold[g*GRP_W +: GRP_W]),
      .drv_o    (drv_o[g*GRP_W +: GRP_W]),
      .oe_o     (drv_oe_o[g])
    );

    AST_RUN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i |-> (drv_o[g*GRP_W +: GRP_W] == grp_data_i[g*GRP_W +: GRP_W]) && drv_oe_o[g]); // R4
    AST_Z_ONLY_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drv_oe_o[g] |-> (!run_i && btype == BT_DIFF && !ctrl[g])); // R6
    AST_ANLG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && btype == BT_ANLG && !ctrl[g]) |-> drv_o[g*GRP_W +: GRP_W] == '0); // R7
  end

  AST_RST_CLEAR: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> cfg_rdata_o == '0); // R1
endmodule

// File: tb/stop_safe_out_bench.sv
`timescale 1ns/1ps
module stop_safe_out_bench;
  localparam int NG = 4;
  localparam int GW = 4;
  localparam int DW = NG * GW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic          rt_we_i = 1'b0;
  logic [15:0]   wr_data_i = '0;
  logic [15:0]   cfg_rdata_o;
  logic          run_i = 1'b1;
  logic [1:0]    diff_mode_i = '0;
  logic [2*NG-1:0] board_type_i = '0;
  logic [DW-1:0] grp_data_i = '0;
  logic [DW-1:0] drv_o;
  logic [NG-1:0] drv_oe_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  stop_safe_out #(.REG_W(16), .NUM_GRP(NG), .GRP_W(GW)) u_stop_safe_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .rt_we_i(rt_we_i),
    .wr_data_i(wr_data_i), .cfg_rdata_o(cfg_rdata_o), .run_i(run_i),
    .diff_mode_i(diff_mode_i), .board_type_i(board_type_i),
    .grp_data_i(grp_data_i), .drv_o(drv_o), .drv_oe_o(drv_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // expected stopped outputs from the requirements: {oe, drv}
  function automatic logic [31:0] exp_stop(input logic [3:0] c, input logic [1:0] m,
                                           input logic [2*NG-1:0] bt, input logic [DW-1:0] held);
    logic [DW-1:0] d = '0;
    logic [NG-1:0] oe = '1;
    for (int g = 0; g < NG; g++) begin
      logic [1:0] t = bt[2*g +: 2];
      if (!c[g]) begin
        if (t == 2'b01) oe[g] = 1'b0;
      end else if (t == 2'b01 && m == 2'b01) d[g*GW +: GW] = '0;
      else if (t == 2'b01 && m == 2'b10) d[g*GW +: GW] = '1;
      else d[g*GW +: GW] = held[g*GW +: GW];
    end
    return {12'h0, oe, d};
  endfunction

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 rdata in reset", 32'(cfg_rdata_o), 32'h0);
    rst_ni = 1'b1;
    tick();
    chk("R1 rdata after reset", 32'(cfg_rdata_o), 32'h0);

    for (int t = 0; t < 4; t++) begin
      for (int m = 0; m < 4; m++) begin
        for (int c = 0; c < 16; c++) begin
          logic [2*NG-1:0] bt;
          logic [DW-1:0] p;
          logic [3:0] cn;
          for (int g = 0; g < NG; g++) bt[2*g +: 2] = 2'((g + t) % 4);
          p  = 16'hA5C3 ^ 16'(c * 16'h1357) ^ 16'(m << 9) ^ 16'(t * 16'h0F1);
          cn = ~4'(c);
          // run phase and configuration write (upper bits set to probe masking)
          run_i = 1'b1;
          board_type_i = bt;
          diff_mode_i = 2'(m);
          grp_data_i = p;
          cfg_we_i = 1'b1;
          wr_data_i = 16'hFFF0 | 16'(c);
          tick();
          cfg_we_i = 1'b0;
          chk("R2 readback", 32'(cfg_rdata_o), 32'(c));
          chk("R4 run pass", 32'({drv_oe_o, drv_o}), {12'h0, 4'hF, p});
          // stop and change the input data
          run_i = 1'b0;
          grp_data_i = ~p;
          #1;
          chk("R5 R6 R7 R8 R9 stop", 32'({drv_oe_o, drv_o}), exp_stop(4'(c), 2'(m), bt, p));
          tick();
          chk("R11 hold kept", 32'({drv_oe_o, drv_o}), exp_stop(4'(c), 2'(m), bt, p));
          // write while stopped
          cfg_we_i = 1'b1;
          wr_data_i = 16'(cn);
          tick();
          cfg_we_i = 1'b0;
          chk("R10 stopped write", 32'({drv_oe_o, drv_o}), exp_stop(cn, 2'(m), bt, p));
          // runtime write must be rejected
          rt_we_i = 1'b1;
          wr_data_i = 16'(c);
          tick();
          rt_we_i = 1'b0;
          chk("R3 rt write rdata", 32'(cfg_rdata_o), 32'(cn));
          chk("R3 rt write outputs", 32'({drv_oe_o, drv_o}), exp_stop(cn, 2'(m), bt, p));
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule